// File: doc/BRIEF.md
# Multi-ratio aligned clock divider

This block takes one fast source clock and derives a family of clocks from it. It produces a processor clock at half the source rate, a quarter-rate auxiliary clock, a bus clock whose ratio to the source depends on a 2-bit ratio select, and a skewed-duty bus clock that shares the bus rising edges but has its own high time. A set of output groups, each with two pins, can route the processor, bus or quarter clock to its pins, or release both pins to high impedance.

All derived clocks come from registers clocked by the source. The outputs are decodes of one phase counter that wraps every 24 source cycles, so every rising edge falls on the same source edge as a rising edge of the processor clock. A test-enable input replaces the source with an external test clock. In test mode the otherwise idle ratio code 11 gives a half-rate bus pair. The ratio code and test flag are taken in only at the start of each 24-cycle frame, so a ratio change never shortens a pulse. An active-low asynchronous reset clears the counter and forces every output low. The first source edge after reset is released raises all derived clocks together.

Top module: `ratio_clk_div`

## Requirements
- R1: `proc_clk_o` toggles on every source edge after reset release, giving half the source rate at 50% duty.
- R2: `quad_clk_o` has a period of 4 source cycles: high for 2 cycles, then low for 2. It changes only on edges where `proc_clk_o` rises.
- R3: With ratio code 00, `bus_clk_o` has a period of 6 source cycles and is high for 3 of them. `skew_clk_o` has a period of 6 and is high for 4 of them.
- R4: With ratio code 01, `bus_clk_o` has a period of 8 and is high for 4 of them. `skew_clk_o` has a period of 8 and is high for 6 of them.
- R5: With ratio code 10, `bus_clk_o` has a period of 4 and is high for 2 of them. `skew_clk_o` has a period of 12 and is high for 6 of them.
- R6: With ratio code 11 and test mode off, `bus_clk_o` and `skew_clk_o` stay low, while `proc_clk_o` and `quad_clk_o` keep running.
- R7: With `test_en_i` high, `test_clk_i` is the source for all outputs. With ratio code 11 in test mode, `bus_clk_o` and `skew_clk_o` both run at half the test clock rate in phase with `proc_clk_o`.
- R8: Every rising edge of `bus_clk_o`, `skew_clk_o` and `quad_clk_o` falls on a source edge where `proc_clk_o` also rises.
- R9: Group g uses the selector bits `grp_sel_i[2g+1:2g]`. Code 00 drives the processor clock on both pins `grp_clk_o[2g+1:2g]`, code 01 the bus clock, code 10 the quarter clock, and code 11 high impedance. The selector is registered on the same edge as the clocks it routes.
- R10: While `rst_ni` is low, all clock outputs and all group pins are driven low. On the first source edge after release, every derived clock and every group pin that is not tristated goes high.
- R11: The ratio code and the test flag are sampled only at frame phase 0. The phase is the number of source edges since reset release minus one, modulo 24. A new code first shows on the outputs at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| test_clk_i | input | 1 | External test clock, used when test_en_i is high |
| test_en_i | input | 1 | Selects the test clock as source and enables the test divide table |
| rst_ni | input | 1 | Active-low asynchronous reset of the divider state |
| ratio_sel_i | input | 2 | Bus ratio code: 00 six, 01 eight, 10 four, 11 auxiliary |
| grp_sel_i | input | 2*NUM_GRP | Per-group route select, 2 bits per group |
| proc_clk_o | output | 1 | Processor clock, half source rate |
| bus_clk_o | output | 1 | Bus clock, ratio set by ratio_sel_i |
| skew_clk_o | output | 1 | Bus clock with mode-dependent duty cycle |
| quad_clk_o | output | 1 | Quarter-rate auxiliary clock |
| grp_clk_o | output | 2*NUM_GRP | Group output pins, two per group, tristate capable |

## Verification
On every source edge, the assertions check that the processor clock toggles and that the quarter clock only changes on a rising processor edge. They also check that bus, skewed and quarter rises line up with processor rises, and that outputs stay low in reset. The bench covers what needs a whole sequence. It measures the exact high and low times for each ratio code, with and without test mode. It checks group routing and high impedance under a selector that changes every cycle. It also confirms that a ratio change made mid-frame waits until the next frame start.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int unsigned DIV_6X   = 6;
  localparam int unsigned DIV_8X   = 8;
  localparam int unsigned DIV_4X   = 4;
  localparam int unsigned DIV_SKW4 = 12;
  // frame length: lcm of every ratio in use
  localparam int unsigned PERIOD   = 24;
  localparam int unsigned PW       = $clog2(PERIOD);

  typedef enum logic [1:0] {
    RATIO_6X  = 2'b00,
    RATIO_8X  = 2'b01,
    RATIO_4X  = 2'b10,
    RATIO_AUX = 2'b11
  } ratio_e;

  typedef enum logic [1:0] {
    GSEL_PROC = 2'b00,
    GSEL_BUS  = 2'b01,
    GSEL_QUAD = 2'b10,
    GSEL_OFF  = 2'b11
  } gsel_e;

  typedef struct packed {
    logic proc;
    logic bus;
    logic skew;
    logic quad;
  } clk_vec_t;
endpackage

// File: rtl/rcd_src_sel.sv
module rcd_src_sel (
  input  logic clk_i,
  input  logic test_clk_i,
  input  logic test_en_i,
  output logic src_clk_o
);
  assign src_clk_o = test_en_i ? test_clk_i : clk_i;
endmodule

// File: rtl/rcd_phase_cnt.sv
module rcd_phase_cnt #(
  parameter int unsigned PERIOD = 24,
  localparam int unsigned PW    = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] ph_o
);
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ph_q <= '0;
    else if (ph_q == PW'(PERIOD - 1))  ph_q <= '0;
    else                               ph_q <= ph_q + 1'b1;
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/rcd_ratio_latch.sv
module rcd_ratio_latch #(
  parameter int unsigned PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ph_i,
  input  logic [1:0]    ratio_i,
  input  logic          test_i,
  output logic [1:0]    ratio_o,
  output logic          test_o
);
  logic [1:0] ratio_q;
  logic       test_q;
  logic       start;

  assign start = (ph_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= 2'b00;
      test_q  <= 1'b0;
    end else if (start) begin
      ratio_q <= ratio_i;
      test_q  <= test_i;
    end
  end

  // frame start uses the live code so the first frame is already correct
  assign ratio_o = start ? ratio_i : ratio_q;
  assign test_o  = start ? test_i  : test_q;
endmodule

// File: rtl/rcd_decode.sv
module rcd_decode
  import rcd_pkg::*;
#(
  parameter int unsigned PW = 5
) (
  input  logic [PW-1:0] ph_i,
  input  logic [1:0]    ratio_i,
  input  logic          test_i,
  output clk_vec_t      vec_o
);
  int p;

  always_comb begin
    p          = int'(ph_i);
    vec_o.proc = (p % 2) == 0;
    vec_o.quad = (p % 4) < 2;
    unique case (ratio_e'(ratio_i))
      RATIO_6X: begin
        vec_o.bus  = (p % DIV_6X) < (DIV_6X / 2);
        vec_o.skew = (p % DIV_6X) < (DIV_6X * 2 / 3);
      end
      RATIO_8X: begin
        vec_o.bus  = (p % DIV_8X) < (DIV_8X / 2);
        vec_o.skew = (p % DIV_8X) < (DIV_8X * 3 / 4);
      end
      RATIO_4X: begin
        vec_o.bus  = (p % DIV_4X) < (DIV_4X / 2);
        vec_o.skew = (p % DIV_SKW4) < (DIV_SKW4 / 2);
      end
      default: begin
        vec_o.bus  = test_i && ((p % 2) == 0);
        vec_o.skew = test_i && ((p % 2) == 0);
      end
    endcase
  end
endmodule

// File: rtl/rcd_grp_drive.sv
module rcd_grp_drive
  import rcd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  clk_vec_t   nxt_i,
  output logic [1:0] pin_o
);
  logic val_q;
  logic oe_q;
  logic val_d;

  always_comb begin
    unique case (gsel_e'(sel_i))
      GSEL_PROC: val_d = nxt_i.proc;
      GSEL_BUS:  val_d = nxt_i.bus;
      GSEL_QUAD: val_d = nxt_i.quad;
      default:   val_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      val_q <= val_d;
      oe_q  <= (gsel_e'(sel_i) != GSEL_OFF);
    end
  end

  assign pin_o = oe_q ? {2{val_q}} : 2'bzz;
endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
  import rcd_pkg::*;
#(
  parameter int unsigned NUM_GRP = 3,
  localparam int unsigned SW     = 2 * NUM_GRP
) (
  input  logic          clk_i,
  input  logic          test_clk_i,
  input  logic          test_en_i,
  input  logic          rst_ni,
  input  logic [1:0]    ratio_sel_i,
  input  logic [SW-1:0] grp_sel_i,
  output logic          proc_clk_o,
  output logic          bus_clk_o,
  output logic          skew_clk_o,
  output logic          quad_clk_o,
  output logic [SW-1:0] grp_clk_o
);
  logic          src_clk;
  logic [PW-1:0] ph;
  logic [1:0]    ratio_act;
  logic          test_act;
  clk_vec_t      nxt;
  clk_vec_t      out_q;

  rcd_src_sel u_src (
    .clk_i      (clk_i),
    .test_clk_i (test_clk_i),
    .test_en_i  (test_en_i),
    .src_clk_o  (src_clk)
  );

  rcd_phase_cnt #(.PERIOD(PERIOD)) u_cnt (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .ph_o   (ph)
  );

  rcd_ratio_latch #(.PW(PW)) u_latch (
    .clk_i   (src_clk),
    .rst_ni  (rst_ni),
    .ph_i    (ph),
    .ratio_i (ratio_sel_i),
    .test_i  (test_en_i),
    .ratio_o (ratio_act),
    .test_o  (test_act)
  );

  rcd_decode #(.PW(PW)) u_dec (
    .ph_i    (ph),
    .ratio_i (ratio_act),
    .test_i  (test_act),
    .vec_o   (nxt)
  );

  always_ff @(posedge src_clk or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= nxt;
  end

  assign proc_clk_o = out_q.proc;
  assign bus_clk_o  = out_q.bus;
  assign skew_clk_o = out_q.skew;
  assign quad_clk_o = out_q.quad;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    rcd_grp_drive u_grp (
      .clk_i  (src_clk),
      .rst_ni (rst_ni),
      .sel_i  (grp_sel_i[2*g +: 2]),
      .nxt_i  (nxt),
      .pin_o  (grp_clk_o[2*g +: 2])
    );
  end
endmodule

// File: rtl/rcd_chk.sv
module rcd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic proc_i,
  input logic bus_i,
  input logic skew_i,
  input logic quad_i
);
  AST_PROC_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (proc_i != $past(proc_i)));                              // R1

  AST_QUAD_ON_PROC_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_i != $past(quad_i)) |-> $rose(proc_i));                     // R2

  AST_BUS_RISE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_i) |-> $rose(proc_i));                                  // R8

  AST_SKEW_RISE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(skew_i) |-> ($rose(proc_i) && bus_i));                      // R8

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_LOW: assert (!proc_i && !bus_i && !skew_i && !quad_i);  // R10
    end
  end
endmodule

bind ratio_clk_div rcd_chk u_chk (
  .clk_i  (src_clk),
  .rst_ni (rst_ni),
  .proc_i (proc_clk_o),
  .bus_i  (bus_clk_o),
  .skew_i (skew_clk_o),
  .quad_i (quad_clk_o)
);

// File: tb/tb_ratio_clk_div.sv
module tb_ratio_clk_div;
  localparam int NG = 3;

  logic          clk = 1'b0;
  logic          test_clk = 1'b0;
  logic          test_en = 1'b0;
  logic          rst_n = 1'b1;
  logic [1:0]    ratio = 2'b00;
  logic [2*NG-1:0] gsel = '0;
  logic          proc_clk, bus_clk, skew_clk, quad_clk;
  wire  [2*NG-1:0] gpin;
  logic          tb_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;
  always #15 test_clk = ~test_clk;
  assign tb_src = test_en ? test_clk : clk;

  ratio_clk_div #(.NUM_GRP(NG)) dut (
    .clk_i       (clk),
    .test_clk_i  (test_clk),
    .test_en_i   (test_en),
    .rst_ni      (rst_n),
    .ratio_sel_i (ratio),
    .grp_sel_i   (gsel),
    .proc_clk_o  (proc_clk),
    .bus_clk_o   (bus_clk),
    .skew_clk_o  (skew_clk),
    .quad_clk_o  (quad_clk),
    .grp_clk_o   (gpin)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // returns {proc, bus, skew, quad}
  function automatic logic [3:0] model(input int ph, input logic t, input logic [1:0] r);
    logic pr, bu, sk, qu;
    pr = (ph % 2) == 0;
    qu = (ph % 4) < 2;
    case (r)
      2'b00:   begin bu = (ph % 6) < 3; sk = (ph % 6) < 4;  end
      2'b01:   begin bu = (ph % 8) < 4; sk = (ph % 8) < 6;  end
      2'b10:   begin bu = (ph % 4) < 2; sk = (ph % 12) < 6; end
      default: begin bu = t && pr;      sk = t && pr;       end
    endcase
    return {pr, bu, sk, qu};
  endfunction

  function automatic string rtag(input logic t, input logic [1:0] r);
    if (t) return "R7";
    case (r)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // mode: 0 fixed selectors, 1 group0 selector cycles every edge
  task automatic run(input logic t, input logic [1:0] r, input logic [2*NG-1:0] s,
                     input int ncyc, input int chg_at, input logic [1:0] r_new, input int sel_mode);
    logic [1:0] act_r;
    logic       act_t;
    logic [3:0] e;
    string      tg;
    rst_n   = 1'b0;
    test_en = t;
    ratio   = r;
    gsel    = s;
    #50;
    // R10 reset state
    chk("R10", "proc in reset", proc_clk, 1'b0);
    chk("R10", "bus in reset", bus_clk, 1'b0);
    chk("R10", "skew in reset", skew_clk, 1'b0);
    chk("R10", "quad in reset", quad_clk, 1'b0);
    for (int i = 0; i < 2*NG; i++) chk("R10", "group pin in reset", gpin[i], 1'b0);
    @(negedge tb_src);
    rst_n = 1'b1;
    act_r = r;
    act_t = t;
    for (int k = 1; k <= ncyc; k++) begin
      int ph;
      @(negedge tb_src);
      ph = (k - 1) % 24;
      if (ph == 0) begin act_r = ratio; act_t = test_en; end
      e  = model(ph, act_t, act_r);
      tg = (k == 1) ? "R10" : rtag(act_t, act_r);
      chk((k == 1) ? "R10" : "R1", "proc", proc_clk, e[3]);
      chk((k == 1) ? "R10" : "R2", "quad", quad_clk, e[0]);
      chk((chg_at > 0) ? "R11" : tg, "bus", bus_clk, e[2]);
      chk((chg_at > 0) ? "R11" : tg, "skew", skew_clk, e[1]);
      for (int g = 0; g < NG; g++) begin
        logic ev;
        case (gsel[2*g +: 2])
          2'b00:   ev = e[3];
          2'b01:   ev = e[2];
          2'b10:   ev = e[0];
          default: ev = 1'bz;
        endcase
        chk("R9", "group pin lo", gpin[2*g],   ev);
        chk("R9", "group pin hi", gpin[2*g+1], ev);
      end
      if (k == chg_at) ratio = r_new;
      if (sel_mode == 1) gsel[1:0] = 2'(k % 4);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // R3 R4 R5 R6: normal ratio sweep, groups route proc/bus/quad
    for (int r = 0; r < 4; r++) run(1'b0, 2'(r), 6'b10_01_00, 48, 0, 2'b00, 0);
    // R7: test clock sweep, group2 tristated, group0 proc, group1 bus
    for (int r = 0; r < 4; r++) run(1'b1, 2'(r), 6'b11_01_00, 48, 0, 2'b00, 0);
    // R11: mid-frame change from ratio 00 to 01 waits for frame start
    run(1'b0, 2'b00, 6'b10_01_00, 72, 10, 2'b01, 0);
    // R11: change to ratio 10 just before frame boundary
    run(1'b0, 2'b01, 6'b00_10_01, 72, 24, 2'b10, 0);
    // R9: group0 selector cycles every edge including high impedance
    run(1'b0, 2'b10, 6'b01_10_00, 48, 0, 2'b00, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule